// File: doc/BRIEF.md
# Recorder Transport Sequencer

This block is the central sequencer of a multi-track audio recorder. It takes single-cycle, already debounced button events (record, play, stop, track step and power) and walks the recorder through start-up, recording, playback, closing of a storage transaction and track changes. Every start or stop of the capture path, the storage writer and reader and the display passes through it, so no two of those blocks have to coordinate with each other directly.

Start-up is gated on two ready levels, one from storage and one from the display. Recording runs the converter capture and the storage writer together. Stopping a recording first drops both of them, then holds a close request towards storage until storage answers with a done pulse. The header is then final, and only after that pulse does the sequencer return to idle. Playback ends the same way. The track number steps only from idle and wraps back to zero after the last track. The current mode code and the track number are presented to the display together with a one-cycle update strobe.

Top module: `rec_transport_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mode` is 0 (INIT), `track` is 0 and `adc_run`, `store_wr_en`, `store_rd_en`, `store_close_req` and `disp_upd` are low.
- R2: In INIT (mode 0) the block stays in INIT until `store_ready` and `disp_ready` are both high at the same clock edge. One cycle later `mode` is 1 (IDLE).
- R3: In IDLE the buttons are taken in priority order: record first (to mode 2), then play (to mode 4), then track (to mode 6), then power (to mode 7). Stop has no effect in IDLE.
- R4: In REC (mode 2) `adc_run` and `store_wr_en` are high. Only `btn_stop` leaves REC, and it moves to mode 3. Record, play, track and power are ignored.
- R5: In REC_CLOSE (mode 3) `adc_run` and `store_wr_en` are low and `store_close_req` is held high until a `store_done` pulse arrives. The cycle after that pulse, `mode` is 1.
- R6: In PLAY (mode 4) `store_rd_en` is high and only `btn_stop` has an effect, moving to PLAY_CLOSE (mode 5). Mode 5 drops `store_rd_en`, holds `store_close_req` until `store_done`, then returns to mode 1.
- R7: A track event accepted in IDLE enters TRACK (mode 6) for exactly one cycle, with `track` already advanced by one. `track` wraps from NUM_TRACKS-1 to 0, and TRACK always returns to IDLE.
- R8: `track` changes only on a track event accepted in IDLE. A track button held while in TRACK does not advance it again.
- R9: Power in IDLE enters OFF (mode 7), where all four enables are low. In OFF, only power has an effect and it moves to INIT.
- R10: A `store_done` pulse outside modes 3 and 5 has no effect on `mode`, `track` or the enables.
- R11: `disp_upd` is high for one cycle in each cycle where `mode` or `track` differs from its value in the previous cycle, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_rec | input | 1 | Record event, one cycle |
| btn_play | input | 1 | Play event, one cycle |
| btn_stop | input | 1 | Stop event, one cycle |
| btn_trk | input | 1 | Track step event, one cycle |
| btn_pwr | input | 1 | Power toggle event, one cycle |
| store_ready | input | 1 | Storage initialised (level) |
| disp_ready | input | 1 | Display initialised (level) |
| store_done | input | 1 | Storage finished closing the transaction (pulse) |
| adc_run | output | 1 | Converter capture enable |
| store_wr_en | output | 1 | Storage writer enable |
| store_rd_en | output | 1 | Storage reader / playback enable |
| store_close_req | output | 1 | Request to close the open storage transaction |
| mode | output | 3 | Current mode code (0 INIT, 1 IDLE, 2 REC, 3 REC_CLOSE, 4 PLAY, 5 PLAY_CLOSE, 6 TRACK, 7 OFF) |
| track | output | TRK_W (3) | Selected track number |
| disp_upd | output | 1 | Display refresh strobe |

## Verification
The sequencer is first driven with single button events in every mode, which separates the events it accepts from the ones each mode must ignore. Simultaneous buttons in IDLE (record with play, play with track, track with power) show whether the priority order is right. Late and early `store_done` pulses, together with a start-up where only one ready level rises, show that close-out and start-up wait for the right partner. Nine track steps and a held track button separate a correct wrap and a single advance from an off-by-one counter or a repeated step. A bench model that runs one cycle at a time compares every output on every cycle, which also pins down the cycles in which the display strobe fires.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    M_INIT   = 3'd0,
    M_IDLE   = 3'd1,
    M_REC    = 3'd2,
    M_RCLOSE = 3'd3,
    M_PLAY   = 3'd4,
    M_PCLOSE = 3'd5,
    M_TRACK  = 3'd6,
    M_OFF    = 3'd7
  } rtc_mode_e;

  typedef struct packed {
    logic rec;
    logic play;
    logic stop;
    logic trk;
    logic pwr;
  } rtc_btn_t;

  typedef struct packed {
    logic adc;
    logic wr;
    logic rd;
    logic close;
  } rtc_caps_t;

  // Advance a track index, wrapping after the last track.
  function automatic int unsigned trk_next(int unsigned cur, int unsigned num);
    return (cur + 1 >= num) ? 0 : cur + 1;
  endfunction

  // Which peripherals a mode keeps running.
  function automatic rtc_caps_t mode_caps(rtc_mode_e m);
    rtc_caps_t c;
    c.adc   = (m == M_REC);
    c.wr    = (m == M_REC);
    c.rd    = (m == M_PLAY);
    c.close = (m == M_RCLOSE) || (m == M_PCLOSE);
    return c;
  endfunction

endpackage

// File: rtl/rtc_fsm.sv
module rtc_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  rtc_pkg::rtc_btn_t   btn,
  input  logic                store_ready,
  input  logic                disp_ready,
  input  logic                store_done,
  output rtc_pkg::rtc_mode_e  state,
  output logic                ev_trk_step,
  output logic                ev_close_done
);
  import rtc_pkg::*;

  rtc_mode_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      M_INIT:   if (store_ready && disp_ready) nxt = M_IDLE;
      M_IDLE: begin
        if (btn.rec)       nxt = M_REC;
        else if (btn.play) nxt = M_PLAY;
        else if (btn.trk)  nxt = M_TRACK;
        else if (btn.pwr)  nxt = M_OFF;
      end
      M_REC:    if (btn.stop)  nxt = M_RCLOSE;
      M_RCLOSE: if (store_done) nxt = M_IDLE;
      M_PLAY:   if (btn.stop)  nxt = M_PCLOSE;
      M_PCLOSE: if (store_done) nxt = M_IDLE;
      M_TRACK:  nxt = M_IDLE;
      M_OFF:    if (btn.pwr)   nxt = M_INIT;
      default:  nxt = M_INIT;
    endcase
  end

  assign ev_trk_step   = (state == M_IDLE) && (nxt == M_TRACK);
  assign ev_close_done = ((state == M_RCLOSE) || (state == M_PCLOSE)) && store_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= M_INIT;
    else        state <= nxt;
  end

endmodule

// File: rtl/rtc_track_ctr.sv
module rtc_track_ctr #(
  parameter int NUM_TRACKS = 8,
  parameter int TRK_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [TRK_W-1:0] track
);
  import rtc_pkg::*;

  logic [TRK_W-1:0] track_inc;

  assign track_inc = TRK_W'(trk_next(int'(unsigned'(track)), NUM_TRACKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    track <= '0;
    else if (step) track <= track_inc;
  end

endmodule

// File: rtl/rtc_disp_evt.sv
module rtc_disp_evt #(
  parameter int TRK_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rtc_pkg::rtc_mode_e mode,
  input  logic [TRK_W-1:0]   track,
  output logic               ev_mode_chg,
  output logic               ev_trk_chg,
  output logic               disp_upd
);
  import rtc_pkg::*;

  rtc_mode_e        mode_q;
  logic [TRK_W-1:0] track_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_INIT;
      track_q <= '0;
    end else begin
      mode_q  <= mode;
      track_q <= track;
    end
  end

  assign ev_mode_chg = (mode != mode_q);
  assign ev_trk_chg  = (track != track_q);
  assign disp_upd    = ev_mode_chg | ev_trk_chg;

endmodule

// File: rtl/rec_transport_ctrl.sv
module rec_transport_ctrl #(
  parameter  int NUM_TRACKS = 8,
  localparam int TRK_W      = (NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_rec,
  input  logic             btn_play,
  input  logic             btn_stop,
  input  logic             btn_trk,
  input  logic             btn_pwr,
  input  logic             store_ready,
  input  logic             disp_ready,
  input  logic             store_done,
  output logic             adc_run,
  output logic             store_wr_en,
  output logic             store_rd_en,
  output logic             store_close_req,
  output logic [2:0]       mode,
  output logic [TRK_W-1:0] track,
  output logic             disp_upd
);
  import rtc_pkg::*;

  rtc_btn_t  btn;
  rtc_mode_e state;
  rtc_caps_t caps;
  logic      ev_trk_step;
  logic      ev_close_done;
  logic      ev_mode_chg;
  logic      ev_trk_chg;

  assign btn = '{rec: btn_rec, play: btn_play, stop: btn_stop, trk: btn_trk, pwr: btn_pwr};

  rtc_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn           (btn),
    .store_ready   (store_ready),
    .disp_ready    (disp_ready),
    .store_done    (store_done),
    .state         (state),
    .ev_trk_step   (ev_trk_step),
    .ev_close_done (ev_close_done)
  );

  rtc_track_ctr #(.NUM_TRACKS(NUM_TRACKS), .TRK_W(TRK_W)) u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ev_trk_step),
    .track (track)
  );

  rtc_disp_evt #(.TRK_W(TRK_W)) u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (state),
    .track       (track),
    .ev_mode_chg (ev_mode_chg),
    .ev_trk_chg  (ev_trk_chg),
    .disp_upd    (disp_upd)
  );

  assign caps            = mode_caps(state);
  assign adc_run         = caps.adc;
  assign store_wr_en     = caps.wr;
  assign store_rd_en     = caps.rd;
  assign store_close_req = caps.close;
  assign mode            = state;

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int NUM_TRACKS = 8,
  parameter int TRK_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_rec,
  input logic             btn_play,
  input logic             btn_stop,
  input logic             btn_trk,
  input logic             btn_pwr,
  input logic             store_ready,
  input logic             disp_ready,
  input logic             store_done,
  input logic             adc_run,
  input logic             store_wr_en,
  input logic             store_rd_en,
  input logic             store_close_req,
  input logic [2:0]       mode,
  input logic [TRK_W-1:0] track,
  input logic             disp_upd,
  input logic             ev_trk_step
);
  import rtc_pkg::*;

  a_r2_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_INIT && !(store_ready && disp_ready)) |=> (mode == M_INIT));

  a_r2_init_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_INIT && store_ready && disp_ready) |=> (mode == M_IDLE));

  a_r3_rec_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && btn_rec) |=> (mode == M_REC));

  a_r3_idle_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && !btn_rec && !btn_play && !btn_trk && !btn_pwr) |=> (mode == M_IDLE));

  a_r4_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_REC && !btn_stop) |=> (mode == M_REC && adc_run && store_wr_en));

  a_r4_rec_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_REC && btn_stop) |=> (mode == M_RCLOSE && !adc_run && !store_wr_en));

  a_r5_close_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RCLOSE && !store_done) |=> (mode == M_RCLOSE && store_close_req));

  a_r5_close_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RCLOSE && store_done) |=> (mode == M_IDLE && !store_close_req));

  a_r6_play_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PLAY && btn_stop) |=> (mode == M_PCLOSE && !store_rd_en && store_close_req));

  a_r7_track_once: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TRACK) |=> (mode == M_IDLE));

  a_r7_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trk_step |=> (track == TRK_W'(trk_next(int'(unsigned'($past(track))), NUM_TRACKS))));

  a_r8_track_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_trk_step |=> $stable(track));

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |-> !(adc_run || store_wr_en || store_rd_en || store_close_req));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && store_done && !btn_rec && !btn_play && !btn_trk && !btn_pwr)
      |=> (mode == M_IDLE));

  a_r11_upd_on_chg: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode) || track != $past(track)) |-> disp_upd);

  a_r11_upd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(mode) && $stable(track)) |-> !disp_upd);

endmodule

bind rec_transport_ctrl rtc_checker #(.NUM_TRACKS(NUM_TRACKS), .TRK_W(TRK_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .btn_rec         (btn_rec),
  .btn_play        (btn_play),
  .btn_stop        (btn_stop),
  .btn_trk         (btn_trk),
  .btn_pwr         (btn_pwr),
  .store_ready     (store_ready),
  .disp_ready      (disp_ready),
  .store_done      (store_done),
  .adc_run         (adc_run),
  .store_wr_en     (store_wr_en),
  .store_rd_en     (store_rd_en),
  .store_close_req (store_close_req),
  .mode            (mode),
  .track           (track),
  .disp_upd        (disp_upd),
  .ev_trk_step     (ev_trk_step)
);

// File: tb/sim_rec_transport_ctrl.sv
`timescale 1ns/1ps
module sim_rec_transport_ctrl;
  localparam int NT = 8;
  localparam int TW = 3;

  localparam logic [5:0] B_REC  = 6'b100000;
  localparam logic [5:0] B_PLAY = 6'b010000;
  localparam logic [5:0] B_STOP = 6'b001000;
  localparam logic [5:0] B_TRK  = 6'b000100;
  localparam logic [5:0] B_PWR  = 6'b000010;
  localparam logic [5:0] B_DONE = 6'b000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_rec = 0, btn_play = 0, btn_stop = 0, btn_trk = 0, btn_pwr = 0;
  logic store_ready = 0, disp_ready = 0, store_done = 0;
  logic adc_run, store_wr_en, store_rd_en, store_close_req, disp_upd;
  logic [2:0] mode;
  logic [TW-1:0] track;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  int em = 0, et = 0, pm = 0, pt = 0;

  always #2.5 clk = ~clk;

  rec_transport_ctrl #(.NUM_TRACKS(NT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .btn_rec(btn_rec), .btn_play(btn_play), .btn_stop(btn_stop),
    .btn_trk(btn_trk), .btn_pwr(btn_pwr),
    .store_ready(store_ready), .disp_ready(disp_ready), .store_done(store_done),
    .adc_run(adc_run), .store_wr_en(store_wr_en), .store_rd_en(store_rd_en),
    .store_close_req(store_close_req), .mode(mode), .track(track), .disp_upd(disp_upd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      em = 0; et = 0; pm = 0; pt = 0;
    end else begin
      pm = em; pt = et;
      case (em)
        0: if (store_ready && disp_ready) em = 1;
        1: begin
          if (btn_rec) em = 2;
          else if (btn_play) em = 4;
          else if (btn_trk) begin em = 6; et = (et + 1) % NT; end
          else if (btn_pwr) em = 7;
        end
        2: if (btn_stop) em = 3;
        3: if (store_done) em = 1;
        4: if (btn_stop) em = 5;
        5: if (store_done) em = 1;
        6: em = 1;
        default: if (btn_pwr) em = 0;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cyc > 0 && !finished) begin
      chk(mtag(em), "mode", int'(mode), em);
      chk("R8", "track", int'(track), et);
      chk("R4", "adc_run", int'(adc_run), int'(em == 2));
      chk("R4", "store_wr_en", int'(store_wr_en), int'(em == 2));
      chk("R6", "store_rd_en", int'(store_rd_en), int'(em == 4));
      chk("R5", "store_close_req", int'(store_close_req), int'(em == 3 || em == 5));
      chk("R11", "disp_upd", int'(disp_upd), int'(em != pm || et != pt));
    end
  end

  task automatic press(input logic [5:0] b, input int n = 1);
    {btn_rec, btn_play, btn_stop, btn_trk, btn_pwr, store_done} = b;
    repeat (n) @(negedge clk);
    {btn_rec, btn_play, btn_stop, btn_trk, btn_pwr, store_done} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 50000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode in reset", int'(mode), 0);
    chk("R1", "track in reset", int'(track), 0);
    chk("R1", "enables in reset", int'({adc_run, store_wr_en, store_rd_en, store_close_req, disp_upd}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mode after reset", int'(mode), 0);

    // R2 start-up needs both ready levels
    store_ready = 1;
    idle(4);
    chk("R2", "mode with one ready", int'(mode), 0);
    disp_ready = 1;
    @(negedge clk);
    chk("R2", "mode after both ready", int'(mode), 1);
    idle(2);

    // R3 stop in idle, R10 done in idle
    press(B_STOP);
    chk("R3", "stop ignored in idle", int'(mode), 1);
    press(B_DONE);
    chk("R10", "done ignored in idle", int'(mode), 1);

    // R3 record beats play
    press(B_REC | B_PLAY);
    chk("R3", "rec priority", int'(mode), 2);

    // R4 record ignores other buttons
    press(B_PLAY); press(B_TRK); press(B_PWR); press(B_REC);
    chk("R4", "rec holds", int'(mode), 2);
    chk("R4", "adc_run in rec", int'(adc_run), 1);
    press(B_DONE);
    chk("R10", "done ignored in rec", int'(mode), 2);

    // R5 close-out of a recording
    press(B_STOP);
    chk("R5", "enter rec close", int'(mode), 3);
    chk("R5", "adc stopped", int'(adc_run), 0);
    idle(3);
    chk("R5", "close waits", int'(store_close_req), 1);
    press(B_DONE);
    chk("R5", "back to idle", int'(mode), 1);

    // R6 playback and its close-out
    press(B_PLAY);
    chk("R6", "enter play", int'(store_rd_en), 1);
    press(B_REC); press(B_TRK);
    chk("R6", "play holds", int'(mode), 4);
    press(B_STOP);
    chk("R6", "enter play close", int'(mode), 5);
    idle(2);
    press(B_DONE);
    chk("R6", "play close done", int'(mode), 1);

    // R7 nine steps wrap past the last track
    for (int i = 0; i < 9; i++) begin
      press(B_TRK);
      if (i == 0) chk("R7", "track mode", int'(mode), 6);
      idle(1);
    end
    chk("R7", "track after wrap", int'(track), 1);

    // R8 held track button advances once
    press(B_TRK, 2);
    chk("R8", "held track single step", int'(track), 2);
    chk("R8", "held track back to idle", int'(mode), 1);

    // R3 play beats track, track beats power
    press(B_PLAY | B_TRK);
    chk("R3", "play priority", int'(mode), 4);
    press(B_STOP); press(B_DONE);
    press(B_TRK | B_PWR);
    chk("R3", "track priority", int'(mode), 6);
    idle(1);

    // R9 power off and on
    press(B_PWR);
    chk("R9", "off", int'(mode), 7);
    press(B_REC);
    chk("R9", "rec ignored in off", int'(mode), 7);
    press(B_PWR);
    chk("R9", "power on to init", int'(mode), 0);
    idle(2);
    chk("R9", "init to idle", int'(mode), 1);

    // R11 strobe timing
    press(B_TRK);
    chk("R11", "strobe on track", int'(disp_upd), 1);
    idle(1);
    chk("R11", "strobe on return", int'(disp_upd), 1);
    idle(1);
    chk("R11", "strobe quiet", int'(disp_upd), 0);

    idle(3);
    finish_run();
  end

endmodule